// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A word-organised static memory in which every control, address and write-data input is captured on the rising clock edge. Each word is split into byte lanes of nine bits. An access begins on one of two address strobes. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write according to the write controls. After an access has begun, an internal two-bit counter walks the two lowest address bits through a four-beat burst. The counter moves on one beat each cycle that the advance input is low, and it waits while that input is high. A static order input selects either a wrap-around increment or an XOR-with-count sequence.

Read data goes through one extra output register, so a read address captured at edge N shows at the output after edge N+1. An asynchronous active-low output enable gates the data output. The port `dq_oe` marks the cycles in which the bus would be driven. Three chip enables give depth expansion. A sleep input blocks all array accesses.

Top module: `burst_sram`

## Requirements
- R1: With `order_sel` low, burst beat k (k = 0..3) from start offset s accesses the word whose two lowest address bits are (s + k) mod 4. The upper address bits stay as captured.
- R2: With `order_sel` high, beat k accesses the word whose two lowest address bits are s XOR k.
- R3: An edge with `adv_n` high during a burst repeats the current burst address. An edge with `adv_n` low moves to the next beat.
- R4: `adsp_n` low with `ce_n` low loads the address and starts a read, even when write controls are asserted. It has priority over `adsc_n`. With `ce_n` high, `adsp_n` is ignored and `adsc_n` alone decides the cycle.
- R5: `adsc_n` low (without a taken `adsp_n`) loads the address. The cycle is a write when any lane is enabled for writing, and a read otherwise.
- R6: The device is selected only when `ce_n` is low, `ce2` is high and `ce3_n` is low. A strobe that loads while not selected performs no access and ends the burst. `dq_oe` is low after the following edge.
- R7: With `gw_n` high and `bwe_n` low, lane i (bits 9i+8..9i) is written exactly when `bw_n[i]` is low. With `bwe_n` high, `bw_n` has no effect.
- R8: `gw_n` low writes all four lanes, whatever `bwe_n` and `bw_n` are.
- R9: The data of a read address captured at edge N appears on `dq_q`, with `dq_oe` high, after edge N+1. After edge N, the previous output is still held.
- R10: While `oe_n` is high, `dq_oe` is low and `dq_q` is all zeros. This follows `oe_n` without waiting for a clock edge.
- R11: While `sleep` is high, no read or write takes place and the burst state is frozen.
- R12: After reset, no burst is active and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Expansion enable, active high |
| ce3_n | input | 1 | Expansion enable, active low |
| adsp_n | input | 1 | Processor address strobe, forces read |
| adsc_n | input | 1 | Controller address strobe |
| adv_n | input | 1 | Burst advance, low steps the counter |
| gw_n | input | 1 | Global write, all lanes |
| bwe_n | input | 1 | Byte write qualifier |
| bw_n | input | LANES | Per-lane write enables, active low |
| wdata | input | LANES*LANE_W | Write data |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby, blocks accesses |
| dq_q | output | LANES*LANE_W | Read data, zero when not driven |
| dq_oe | output | 1 | Output drive indication |

## Verification
The hardest case to reach is an address sequence that exists only inside the burst counter. The bench must see every start offset in both orders, and waits between beats, using nothing but read data. To reach it, every word of a region is first filled with a distinct address-derived pattern. A burst is then opened at each offset in turn, and each returned word is matched to the beat address it must have come from. The bench also drives strobe collisions, and strobes issued while deselected or asleep, with a full global write. Each of these is followed by a read-back, which shows that no write leaked through.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      ce_n,
  input  logic                      ce2,
  input  logic                      ce3_n,
  input  logic                      adsp_n,
  input  logic                      adsc_n,
  input  logic                      adv_n,
  input  logic                      gw_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      order_sel,
  input  logic                      oe_n,
  input  logic                      sleep,
  output logic [LANES*LANE_W-1:0]   dq_q,
  output logic                      dq_oe
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              active;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_pend;
  logic [DATA_W-1:0] q;
  logic              q_ok;

  wire chip_sel = ~ce_n & ce2 & ~ce3_n;
  wire take_p   = ~adsp_n & ~ce_n;
  wire take_c   = ~take_p & ~adsc_n;
  wire load     = take_p | take_c;

  logic [1:0]        cnt_nx, start, low;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_mask;

  always_comb begin
    cnt_nx   = load ? 2'd0 : cnt + {1'b0, ~adv_n};
    start    = load ? addr[1:0] : base[1:0];
    low      = order_sel ? (start ^ cnt_nx) : (start + cnt_nx);
    acc_addr = load ? addr : base;
    acc_addr[1:0] = low;
    lane_mask = ~gw_n ? '1 : (bwe_n ? '0 : ~bw_n);
  end

  wire acc_en = ~sleep & (load ? chip_sel : active);
  wire do_wr  = acc_en & ~take_p & (|lane_mask);
  wire do_rd  = acc_en & ~do_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      base    <= '0;
      cnt     <= '0;
      rd_pend <= 1'b0;
      rd_addr <= '0;
      q_ok    <= 1'b0;
      q       <= '0;
    end else begin
      if (!sleep) begin
        cnt <= cnt_nx;
        if (load) begin
          active <= chip_sel;
          base   <= addr;
        end
      end
      rd_pend <= do_rd;
      rd_addr <= acc_addr;
      q_ok    <= rd_pend;
      if (rd_pend) q <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (do_wr && lane_mask[i])
        mem[acc_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
  end

  assign dq_oe = ~oe_n & q_ok;
  assign dq_q  = dq_oe ? q : '0;

  assert_wait_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && adv_n && !sleep) |=> (cnt == $past(cnt)));

  assert_adsp_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_p && chip_sel && !sleep) |=> rd_pend);

  assert_deselect_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !chip_sel && !sleep) |=> (!rd_pend ##1 !q_ok));

  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> q_ok);

  assert_sleep_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rd_pend);

  always_comb begin
    if (rst_n && oe_n) assert_oe_gate_R10: assert (!dq_oe && dq_q == '0);
  end
endmodule

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        ce_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n;
  logic [3:0]  bw_n;
  logic [35:0] wdata;
  logic        order_sel, oe_n, sleep;
  logic [35:0] dq_q;
  logic        dq_oe;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .wdata(wdata), .order_sel(order_sel), .oe_n(oe_n), .sleep(sleep),
    .dq_q(dq_q), .dq_oe(dq_oe)
  );

  always #10 clk = ~clk;

  // byte-write vectors: {gw_n, bwe_n, bw_n[3:0], expected lane mask[3:0]}
  localparam logic [9:0] BYTE_VEC [8] = '{
    {1'b0, 1'b1, 4'hF, 4'hF},
    {1'b0, 1'b0, 4'h0, 4'hF},
    {1'b0, 1'b1, 4'h0, 4'hF},
    {1'b1, 1'b1, 4'h0, 4'h0},
    {1'b1, 1'b0, 4'hE, 4'h1},
    {1'b1, 1'b0, 4'h7, 4'h8},
    {1'b1, 1'b0, 4'h5, 4'hA},
    {1'b1, 1'b0, 4'hF, 4'h0}
  };

  function automatic logic [35:0] pat(input int a);
    logic [35:0] v;
    v = 36'(a) * 36'd2654435761;
    return v ^ 36'h912345678;
  endfunction

  function automatic logic [35:0] expand(input logic [3:0] m);
    logic [35:0] v;
    for (int i = 0; i < 4; i++) v[i*9 +: 9] = {9{m[i]}};
    return v;
  endfunction

  task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    addr = '0; ce_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF; wdata = '0;
    oe_n = 1'b0; sleep = 1'b0;
  endtask

  task automatic wr_word(input int a, input logic [35:0] d);
    adsc_n = 1'b0; addr = 8'(a); gw_n = 1'b0; wdata = d;
    tick();
    idle();
  endtask

  task automatic rd_word(input int a, output logic [35:0] d, output logic oe);
    adsc_n = 1'b0; addr = 8'(a);
    tick();
    idle();
    tick();
    d = dq_q; oe = dq_oe;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [35:0] d;
    logic oe;
    int lo;
    order_sel = 1'b0;
    idle();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R12 dq_oe after reset", 36'(dq_oe), 36'd0);

    for (int a = 0; a < 64; a++) wr_word(a, pat(a));

    rd_word(5, d, oe);
    chk("R5 read via adsc", d, pat(5));
    chk("R9 dq_oe on read", 36'(oe), 36'd1);

    // latency: previous output held after edge N, new data after N+1
    rd_word(3, d, oe);
    adsc_n = 1'b0; addr = 8'd17;
    tick();
    idle();
    chk("R9 held after edge N", dq_q, pat(3));
    tick();
    chk("R9 valid after edge N+1", dq_q, pat(17));

    // burst sequences from every start offset in both orders
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        order_sel = m[0];
        adsp_n = 1'b0; addr = 8'h20 | 8'(s);
        tick();
        adsp_n = 1'b1; adv_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
          tick();
          lo = (m == 0) ? ((s + k) % 4) : (s ^ k);
          chk(m == 0 ? "R1 linear beat" : "R2 interleaved beat", dq_q, pat(32 + lo));
        end
        idle();
      end
    end
    order_sel = 1'b0;

    // wait cycles hold the burst address
    adsp_n = 1'b0; addr = 8'h26;
    tick();
    adsp_n = 1'b1; adv_n = 1'b1;
    tick();
    chk("R3 beat0", dq_q, pat(38));
    tick();
    chk("R3 wait 1", dq_q, pat(38));
    adv_n = 1'b0;
    tick();
    chk("R3 wait 2", dq_q, pat(38));
    tick();
    chk("R3 advance after wait", dq_q, pat(39));
    idle();

    // adsp forces read, even with write controls and adsc asserted
    adsp_n = 1'b0; adsc_n = 1'b0; gw_n = 1'b0; addr = 8'd5; wdata = 36'h0DEADBEEF;
    tick();
    idle();
    tick();
    chk("R4 adsp read data", dq_q, pat(5));
    rd_word(5, d, oe);
    chk("R4 adsp did not write", d, pat(5));

    // adsp ignored when ce_n high: adsc deselects, no write
    ce_n = 1'b1; adsp_n = 1'b0; adsc_n = 1'b0; gw_n = 1'b0; addr = 8'd6; wdata = '1;
    tick();
    idle();
    tick();
    chk("R4 ce_n high no output", 36'(dq_oe), 36'd0);
    rd_word(6, d, oe);
    chk("R4 ce_n high no write", d, pat(6));

    // deselect through ce2 and ce3_n
    ce2 = 1'b0; adsc_n = 1'b0; gw_n = 1'b0; addr = 8'd12; wdata = '1;
    tick();
    idle();
    tick();
    chk("R6 ce2 low output off", 36'(dq_oe), 36'd0);
    rd_word(12, d, oe);
    chk("R6 ce2 low no write", d, pat(12));
    ce3_n = 1'b1; adsc_n = 1'b0; gw_n = 1'b0; addr = 8'd13; wdata = '1;
    tick();
    idle();
    tick();
    chk("R6 ce3_n high output off", 36'(dq_oe), 36'd0);
    rd_word(13, d, oe);
    chk("R6 ce3_n high no write", d, pat(13));

    // byte and global writes from the vector table
    for (int v = 0; v < 8; v++) begin
      wr_word(9, '0);
      adsc_n = 1'b0; addr = 8'd9; wdata = '1;
      gw_n = BYTE_VEC[v][9]; bwe_n = BYTE_VEC[v][8]; bw_n = BYTE_VEC[v][7:4];
      tick();
      idle();
      rd_word(9, d, oe);
      chk(BYTE_VEC[v][9] ? "R7 byte write vector" : "R8 global write vector",
          d, expand(BYTE_VEC[v][3:0]));
    end
    for (int b = 0; b < 16; b++) begin
      wr_word(10, '0);
      adsc_n = 1'b0; addr = 8'd10; wdata = '1; bwe_n = 1'b0; bw_n = 4'(b);
      tick();
      idle();
      rd_word(10, d, oe);
      chk("R7 lane mask sweep", d, expand(~4'(b)));
    end

    // output enable is asynchronous
    rd_word(21, d, oe);
    oe_n = 1'b1;
    #1;
    chk("R10 oe_n high drive", 36'(dq_oe), 36'd0);
    chk("R10 oe_n high data", dq_q, 36'd0);
    oe_n = 1'b0;
    #1;
    chk("R10 oe_n low drive", 36'(dq_oe), 36'd1);
    chk("R10 oe_n low data", dq_q, pat(21));

    // sleep blocks accesses
    sleep = 1'b1; adsc_n = 1'b0; gw_n = 1'b0; addr = 8'd7; wdata = '1;
    tick();
    adsc_n = 1'b1; gw_n = 1'b1;
    tick();
    chk("R11 no read in sleep", 36'(dq_oe), 36'd0);
    idle();
    rd_word(7, d, oe);
    chk("R11 no write in sleep", d, pat(7));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule